// File: doc/BRIEF.md
# Statically scheduled variable storage memory

This block holds the intermediate words of a periodic datapath whose schedule is fixed when the design is built. A free-running slot counter walks through the schedule period. Three elaboration-time tables give, for every stored variable, the slot in which it is written, the memory cell it lives in, and how many slots later each of its reads falls. From the current slot the block derives its own write and read strobes and cell addresses. The surrounding datapath therefore only presents a word on `data_i` in the write slot, and picks it up from `data_o` after the read slot.

Variables whose live intervals do not overlap may share a cell, so the memory depth is the number of assigned cells rather than the number of variables. The default table is a 4x4 matrix transpose with 13-bit words. The sixteen elements are written row by row in slots 0 to 15. They are read back column by column, and the shortest lifetime is 5 slots. The period is 32 slots and 14 cells are used.

Top module: `sched_var_mem`

## Requirements
- R1: The slot counter starts at 0 after reset, advances by one in each clock cycle with `en_i` high, and wraps from period minus 1 to 0. Frames issued in later periods line up with the same slots as the first frame.
- R2: In an enabled cycle whose slot equals a variable's write time, `data_i` is stored in that variable's cell. In the default table, variable v = 4*row + col is written in slot v.
- R3: In an enabled cycle whose slot equals (write time + lifetime) mod period, the variable's cell is read. The word appears on `data_o` after the next rising edge. In the default table, element (row, col) is read in slot 14 + 4*col + row, so `data_o` delivers the transpose in column order.
- R4: While `en_i` is low the counter holds, nothing is written (the word on `data_i` is discarded), and `data_o` keeps its value.
- R5: In an enabled slot with no scheduled read, `data_o` keeps its previous value. Slots with no scheduled access decode to address 0 with the strobe low.
- R6: Two variables assigned to one cell are both returned intact. In the default table, cell 0 holds elements 0 and 14, and cell 4 holds elements 4 and 15. Those reuse reads occur in slots 25 and 29.
- R7: When one cell is read and written in the same slot, the read returns the word stored before that write. This happens in default slot 14 (cell 0) and slot 15 (cell 4).
- R8: An active-low asynchronous reset clears `data_o` to 0 and returns the counter to slot 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Advances the schedule and permits accesses |
| data_i | input | WORD_W | Word stored in a write slot |
| data_o | output | WORD_W | Registered word from the last read slot |

## Verification
The bench builds the block with its default parameters: the 4x4 transpose table, a 32-slot period, 14 cells and 13-bit words. This table places shared cells and same-slot read/write collisions inside every frame, so cell reuse and read-before-write ordering are exercised in ordinary traffic. Because the period is longer than the frame, idle slots with no scheduled read also occur in each frame. Stalls are placed both on a write slot, with a junk word on the input, and on a read slot. A reset is applied in the middle of the run and followed by a fresh frame.

// File: rtl/sched_mem_pkg.sv
package sched_mem_pkg;

  // Width of one entry in the packed schedule tables.
  localparam int unsigned FIELD_W = 8;

  // Default table: DIM x DIM transpose, row-major writes, column-major reads.
  localparam int unsigned TP_DIM      = 4;
  localparam int unsigned TP_VARS     = TP_DIM * TP_DIM;
  localparam int unsigned TP_MIN_LIFE = 5;
  localparam int unsigned TP_OFFSET   = TP_MIN_LIFE + (TP_DIM - 1) * (TP_DIM - 1);
  localparam int unsigned TP_PERIOD   = 32;
  localparam int unsigned TP_CELLS    = 14;

  function automatic logic [TP_VARS*FIELD_W-1:0] tp_write_times();
    logic [TP_VARS*FIELD_W-1:0] r;
    r = '0;
    for (int v = 0; v < TP_VARS; v++) r[v*FIELD_W +: FIELD_W] = FIELD_W'(v);
    return r;
  endfunction

  function automatic logic [TP_VARS*FIELD_W-1:0] tp_lifetimes();
    logic [TP_VARS*FIELD_W-1:0] r;
    int row, col, life;
    r = '0;
    for (int v = 0; v < TP_VARS; v++) begin
      row  = v / TP_DIM;
      col  = v % TP_DIM;
      life = (TP_DIM - 1) * (col - row) + TP_OFFSET;
      r[v*FIELD_W +: FIELD_W] = FIELD_W'(life);
    end
    return r;
  endfunction

  // Cell per variable, variable 15 in the top field; 14 reuses cell 0, 15 reuses cell 4.
  localparam logic [TP_VARS*FIELD_W-1:0] TP_CELL_MAP = {
    8'd4,  8'd0,  8'd13, 8'd12, 8'd11, 8'd10, 8'd9, 8'd8,
    8'd7,  8'd6,  8'd5,  8'd4,  8'd3,  8'd2,  8'd1, 8'd0
  };

endpackage

// File: rtl/svm_counter.sv
module svm_counter #(
  parameter int unsigned SCHED_LEN = 32,
  parameter int unsigned SLOT_W    = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  output logic [SLOT_W-1:0] slot_o
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SCHED_LEN - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       slot_o <= '0;
    else if (en_i)     slot_o <= (slot_o == LAST) ? '0 : slot_o + 1'b1;
  end

  assert_cnt_wrap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && slot_o == LAST) |=> (slot_o == '0));
  assert_cnt_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(slot_o));
  assert_cnt_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_o <= LAST);
endmodule

// File: rtl/svm_decoder.sv
module svm_decoder
  import sched_mem_pkg::*;
#(
  parameter int unsigned SCHED_LEN = 32,
  parameter int unsigned N_VARS    = 16,
  parameter int unsigned N_READS   = 1,
  parameter int unsigned N_CELLS   = 14,
  parameter int unsigned SLOT_W    = 5,
  parameter int unsigned ADDR_W    = 4,
  parameter logic [N_VARS*FIELD_W-1:0]         WR_TIME = '0,
  parameter logic [N_VARS*FIELD_W-1:0]         CELL    = '0,
  parameter logic [N_VARS*N_READS*FIELD_W-1:0] LIFE    = '0
) (
  input  logic [SLOT_W-1:0] slot_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o
);
  localparam int unsigned N_ACC = N_VARS * N_READS;

  function automatic int unsigned read_slot(int unsigned v, int unsigned k);
    return (int'(WR_TIME[v*FIELD_W +: FIELD_W]) +
            int'(LIFE[(v*N_READS+k)*FIELD_W +: FIELD_W])) % SCHED_LEN;
  endfunction

  function automatic int unsigned worst_writes();
    int unsigned worst, n;
    worst = 0;
    for (int s = 0; s < SCHED_LEN; s++) begin
      n = 0;
      for (int v = 0; v < N_VARS; v++)
        if (int'(WR_TIME[v*FIELD_W +: FIELD_W]) == s) n++;
      if (n > worst) worst = n;
    end
    return worst;
  endfunction

  function automatic int unsigned worst_reads();
    int unsigned worst, n;
    worst = 0;
    for (int s = 0; s < SCHED_LEN; s++) begin
      n = 0;
      for (int v = 0; v < N_VARS; v++)
        for (int k = 0; k < N_READS; k++)
          if (read_slot(v, k) == s) n++;
      if (n > worst) worst = n;
    end
    return worst;
  endfunction

  function automatic bit table_in_range();
    for (int v = 0; v < N_VARS; v++) begin
      if (int'(CELL[v*FIELD_W +: FIELD_W]) >= N_CELLS) return 1'b0;
      if (int'(WR_TIME[v*FIELD_W +: FIELD_W]) >= SCHED_LEN) return 1'b0;
    end
    return 1'b1;
  endfunction

  if (worst_writes() > 1 || worst_reads() > 1 || !table_in_range()) begin : g_bad_table
    $error("schedule table needs more than one access per port in a slot, or is out of range");
  end

  logic [N_VARS-1:0] wr_hit;
  logic [N_ACC-1:0]  rd_hit;

  for (genvar v = 0; v < N_VARS; v++) begin : g_var
    localparam int unsigned WT = int'(WR_TIME[v*FIELD_W +: FIELD_W]);
    assign wr_hit[v] = (slot_i == SLOT_W'(WT));
    for (genvar k = 0; k < N_READS; k++) begin : g_rd
      localparam int unsigned RT = read_slot(v, k);
      assign rd_hit[v*N_READS+k] = (slot_i == SLOT_W'(RT));
    end
  end

  // At most one hit per port, so OR-ing the masked cell indices selects it.
  always_comb begin
    wr_addr_o = '0;
    rd_addr_o = '0;
    for (int v = 0; v < N_VARS; v++) begin
      if (wr_hit[v]) wr_addr_o |= ADDR_W'(CELL[v*FIELD_W +: FIELD_W]);
      for (int k = 0; k < N_READS; k++)
        if (rd_hit[v*N_READS+k]) rd_addr_o |= ADDR_W'(CELL[v*FIELD_W +: FIELD_W]);
    end
  end

  assign wr_en_o = |wr_hit;
  assign rd_en_o = |rd_hit;
endmodule

// File: rtl/svm_ram.sv
module svm_ram #(
  parameter int unsigned WORD_W  = 13,
  parameter int unsigned N_CELLS = 14,
  parameter int unsigned ADDR_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o
);
  logic [WORD_W-1:0] mem [N_CELLS];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[wr_addr_i] <= wr_data_i;
  end

  // Registered read samples the cell before a same-edge write lands.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rd_data_o <= '0;
    else if (rd_en_i)  rd_data_o <= mem[rd_addr_i];
  end

  assert_wr_store_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (mem[$past(wr_addr_i)] == $past(wr_data_i)));
  assert_rd_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

// File: rtl/sched_var_mem.sv
module sched_var_mem
  import sched_mem_pkg::*;
#(
  parameter int unsigned WORD_W    = 13,
  parameter int unsigned SCHED_LEN = sched_mem_pkg::TP_PERIOD,
  parameter int unsigned N_VARS    = sched_mem_pkg::TP_VARS,
  parameter int unsigned N_READS   = 1,
  parameter int unsigned N_CELLS   = sched_mem_pkg::TP_CELLS,
  parameter logic [N_VARS*FIELD_W-1:0]         WR_TIME = sched_mem_pkg::tp_write_times(),
  parameter logic [N_VARS*FIELD_W-1:0]         CELL    = sched_mem_pkg::TP_CELL_MAP,
  parameter logic [N_VARS*N_READS*FIELD_W-1:0] LIFE    = sched_mem_pkg::tp_lifetimes()
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [WORD_W-1:0] data_o
);
  localparam int unsigned SLOT_W = (SCHED_LEN > 1) ? $clog2(SCHED_LEN) : 1;
  localparam int unsigned ADDR_W = (N_CELLS > 1) ? $clog2(N_CELLS) : 1;

  logic [SLOT_W-1:0] slot;
  logic              dec_wr_en, dec_rd_en;
  logic [ADDR_W-1:0] dec_wr_addr, dec_rd_addr;
  logic              wr_req, rd_req;

  svm_counter #(.SCHED_LEN(SCHED_LEN), .SLOT_W(SLOT_W)) u_counter (
    .clk_i, .rst_ni, .en_i, .slot_o(slot)
  );

  svm_decoder #(
    .SCHED_LEN(SCHED_LEN), .N_VARS(N_VARS), .N_READS(N_READS), .N_CELLS(N_CELLS),
    .SLOT_W(SLOT_W), .ADDR_W(ADDR_W), .WR_TIME(WR_TIME), .CELL(CELL), .LIFE(LIFE)
  ) u_decoder (
    .slot_i(slot), .wr_en_o(dec_wr_en), .wr_addr_o(dec_wr_addr),
    .rd_en_o(dec_rd_en), .rd_addr_o(dec_rd_addr)
  );

  // Accesses happen only in cycles that also advance the schedule.
  assign wr_req = dec_wr_en & en_i;
  assign rd_req = dec_rd_en & en_i;

  svm_ram #(.WORD_W(WORD_W), .N_CELLS(N_CELLS), .ADDR_W(ADDR_W)) u_ram (
    .clk_i, .rst_ni,
    .wr_en_i(wr_req), .wr_addr_i(dec_wr_addr), .wr_data_i(data_i),
    .rd_en_i(rd_req), .rd_addr_i(dec_rd_addr), .rd_data_o(data_o)
  );

  assert_stall_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(data_o));
  assert_idle_wr_addr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_wr_en |-> (dec_wr_addr == '0));
  assert_idle_rd_addr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_rd_en |-> (dec_rd_addr == '0));
endmodule

// File: tb/sched_var_mem_tb_top.sv
module sched_var_mem_tb_top;
  localparam int W       = 13;
  localparam int DIM     = 4;
  localparam int NV      = DIM * DIM;
  localparam int PERIOD  = 32;
  localparam int RD_BASE = 14;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         en_i = 1'b0;
  logic [W-1:0] data_i = '0;
  logic [W-1:0] data_o;

  always #4 clk_i = ~clk_i;

  sched_var_mem dut_i (.clk_i, .rst_ni, .en_i, .data_i, .data_o);

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [W-1:0] exp_q[$];
  logic [W-1:0] last_out = '0;
  string cur_tag = "R2";
  int tb_slot = 0, prev_slot = 0;
  logic prev_en = 1'b0;

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h (frame %s, t=%0t)", req, act, exp, cur_tag, $time);
    end
  endtask

  function automatic logic [W-1:0] word(input int f, input int v);
    return W'(f * 811 + v * 97 + 5);
  endfunction

  // Bench model of the slot counter per R1.
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tb_slot <= 0; prev_en <= 1'b0; prev_slot <= 0;
    end else begin
      prev_en   <= en_i;
      prev_slot <= tb_slot;
      if (en_i) tb_slot <= (tb_slot == PERIOD - 1) ? 0 : tb_slot + 1;
    end
  end

  // Monitor: compare after each edge.
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      if (prev_en && prev_slot >= RD_BASE && prev_slot < RD_BASE + NV) begin
        logic [W-1:0] e;
        string req;
        req = (prev_slot == 14 || prev_slot == 15) ? "R7" :
              (prev_slot == 25 || prev_slot == 29) ? "R6" : "R3";
        if (exp_q.size() == 0) begin
          check(1'b0, req, data_o, '0);
        end else begin
          e = exp_q.pop_front();
          check(data_o == e, req, data_o, e);
        end
        last_out = data_o;
      end else begin
        check(data_o == last_out, prev_en ? "R5" : "R4", data_o, last_out);
      end
    end
  end

  // Driver: one schedule period carrying one frame, optional stall.
  task automatic run_frame(input int f, input int stall_at, input int stall_len, input string tag);
    cur_tag = tag;
    for (int r = 0; r < NV; r++) exp_q.push_back(word(f, DIM * (r % DIM) + r / DIM));
    for (int s = 0; s < PERIOD; s++) begin
      if (s == stall_at) begin
        for (int k = 0; k < stall_len; k++) begin
          en_i = 1'b0; data_i = W'(13'h1abc); @(negedge clk_i);
        end
      end
      en_i = 1'b1;
      data_i = (s < NV) ? word(f, s) : W'(13'h0f0f);
      @(negedge clk_i);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(data_o == '0, "R8", data_o, '0);
    rst_ni = 1'b1;
    run_frame(0, -1, 0, "R2");
    run_frame(1, -1, 0, "R1");
    run_frame(2, 5, 3, "R4");
    run_frame(3, 20, 2, "R4");
    en_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check(data_o == '0, "R8", data_o, '0);
    last_out = '0;
    exp_q.delete();
    rst_ni = 1'b1;
    run_frame(4, -1, 0, "R8");
    en_i = 1'b0;
    repeat (2) @(negedge clk_i);
    if (exp_q.size() != 0) check(1'b0, "R3", W'(exp_q.size()), '0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule